// File: doc/BRIEF.md
# Sprite Attribute Memory Access Arbiter

This block owns a 160-byte sprite attribute memory. It decides, access by access, whether the processor bus may touch that memory. A processor access counts only when its address falls inside a fixed window. Permission then depends on two things: whether the block copy engine is moving data, and which phase the display controller reports. While the copy engine runs, it has sole use of the memory. Otherwise the processor gets through only during the two blanking phases. A refused read still completes, but it returns all ones. A refused write has no effect.

The copy engine writes through its own port by table index. Every write on that port is accepted while the engine is flagged active, whatever phase the display is in. Every access completes in a fixed number of cycles, so no back-pressure exists at either port. The strobes are plain single-cycle pulses. A read answers with a one-cycle valid pulse on the following cycle. The memory-side address, data, enable and write-enable are brought out so that the chosen source and the decoded offset can be seen from outside.

Top module: `sprite_mem_arbiter`

## Requirements
- R1: Only processor addresses 0xFE00 to 0xFE9F inclusive are in the window. For any other address, `mem_en` stays low and no read response (`cpu_rvalid`) is produced.
- R2: The processor may reach the memory when `copy_active` is low and `disp_mode` is 0 (horizontal blank) or 1 (vertical blank). A write then stores its byte, and a later read returns the stored byte.
- R3: When `disp_mode` is 2 (sprite scan) or 3 (drawing), an in-window read returns 0xFF and an in-window write leaves the memory unchanged.
- R4: While `copy_active` is high, an in-window processor read returns 0xFF and an in-window processor write leaves the memory unchanged.
- R5: The copy-engine check takes priority over the display phase, so the R4 blocking also applies in modes 0 and 1.
- R6: A copy-port write (`copy_wr`) with `copy_active` high stores `copy_wdata` at `copy_idx` in any display mode. The write is ignored when `copy_active` is low or when `copy_idx` is 160 or more.
- R7: A read response comes exactly one cycle after an in-window read strobe: `cpu_rvalid` is high for that one cycle. `cpu_rdata` is 0 whenever `cpu_rvalid` is low.
- R8: After reset, `cpu_rvalid`, `cpu_rdata` and `mem_en` are all 0 while no strobe is applied.
- R9: For a granted processor write, `mem_addr` equals the address minus 0xFE00, `mem_wdata` equals `cpu_wdata`, and `mem_we` is high. `mem_we` is never high without a granted write from one of the two sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe, one cycle |
| cpu_wr | input | 1 | Processor write strobe, one cycle |
| disp_mode | input | 2 | Display phase: 0 hblank, 1 vblank, 2 scan, 3 draw |
| copy_active | input | 1 | Copy engine is transferring |
| copy_wr | input | 1 | Copy engine write strobe |
| copy_idx | input | 8 | Copy engine table index |
| copy_wdata | input | 8 | Copy engine write data |
| cpu_rdata | output | 8 | Read response data |
| cpu_rvalid | output | 1 | Read response valid, one cycle after the strobe |
| mem_addr | output | 8 | Memory index being accessed |
| mem_wdata | output | 8 | Memory write data |
| mem_en | output | 1 | Memory access granted this cycle |
| mem_we | output | 1 | Memory write granted this cycle |

## Verification
The hardest case to reach is a refused write. Its effect must be shown to be absent, and that can only be seen through a later, permitted read of the same byte. The stimulus therefore first fills the whole table in a blanking phase, keeping a reference copy. It then attempts writes under each blocking condition, including a copy-active write in a blanking phase. Finally it reads those bytes back in an open phase and compares them with the reference copy. Copy-port writes at the last valid index and one past it, and reads at both window edges, cover the boundaries.

// File: rtl/sprite_arb_pkg.sv
package sprite_arb_pkg;
  typedef enum logic [1:0] {
    DM_HBLANK = 2'd0,
    DM_VBLANK = 2'd1,
    DM_SCAN   = 2'd2,
    DM_DRAW   = 2'd3
  } disp_mode_e;

  localparam logic [7:0] BLOCKED_BYTE = 8'hFF;

  function automatic logic mode_open(input disp_mode_e m);
    return (m == DM_HBLANK) || (m == DM_VBLANK);
  endfunction
endpackage

// File: rtl/sprite_win_decode.sv
module sprite_win_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hFE00,
  parameter int DEPTH = 160,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [IDX_W-1:0]  offset
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BASE + ADDR_W'(DEPTH - 1));

  always_comb begin
    in_win = (addr >= BASE) && (addr <= LAST);
    offset = IDX_W'(addr - BASE);
  end
endmodule

// File: rtl/sprite_access_gate.sv
module sprite_access_gate
  import sprite_arb_pkg::*;
#(
  parameter int DEPTH = 160,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_win,
  input  logic [IDX_W-1:0] cpu_off,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [7:0]       cpu_wdata,
  input  disp_mode_e       mode,
  input  logic             copy_active,
  input  logic             copy_wr,
  input  logic [IDX_W-1:0] copy_idx,
  input  logic [7:0]       copy_wdata,
  output logic             mem_en,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             rd_req,
  output logic             rd_open
);
  logic cpu_open;
  logic copy_fire;
  logic cpu_wr_ok;
  logic cpu_rd_ok;

  always_comb begin
    // The copy engine is checked first; the display phase is consulted only when it is idle.
    cpu_open  = !copy_active && mode_open(mode);
    copy_fire = copy_active && copy_wr &&
                ({1'b0, copy_idx} < (IDX_W+1)'(DEPTH));
    cpu_wr_ok = in_win && cpu_wr && cpu_open;
    cpu_rd_ok = in_win && cpu_rd && cpu_open;

    mem_en    = copy_fire || cpu_wr_ok || cpu_rd_ok;
    mem_we    = copy_fire || cpu_wr_ok;
    mem_addr  = '0;
    mem_wdata = '0;
    if (copy_fire) begin
      mem_addr  = copy_idx;
      mem_wdata = copy_wdata;
    end else if (cpu_wr_ok || cpu_rd_ok) begin
      mem_addr  = cpu_off;
      mem_wdata = cpu_wr_ok ? cpu_wdata : '0;
    end

    rd_req  = in_win && cpu_rd;
    rd_open = cpu_open;
  end

  // R5
  copy_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_active && !copy_wr) |-> !mem_en);

  // R1
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_win && !copy_active) |-> !mem_en);

  // R6
  copy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy_active && !cpu_wr) |-> !mem_we);
endmodule

// File: rtl/sprite_ram.sv
module sprite_ram #(
  parameter int DEPTH = 160,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < (IDX_W+1)'(DEPTH))) cells[waddr] <= wdata;
    if (re && ({1'b0, raddr} < (IDX_W+1)'(DEPTH))) rdata <= cells[raddr];
  end
endmodule

// File: rtl/sprite_read_return.sv
module sprite_read_return
  import sprite_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_req,
  input  logic       rd_open,
  input  logic [7:0] ram_q,
  output logic [7:0] rdata,
  output logic       rvalid
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      open_q <= 1'b0;
    end else begin
      rvalid <= rd_req;
      open_q <= rd_open;
    end
  end

  always_comb begin
    if (!rvalid)     rdata = '0;
    else if (open_q) rdata = ram_q;
    else             rdata = BLOCKED_BYTE;
  end

  // R7
  rvalid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid);

  // R7
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rvalid);

  // R7
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == 8'h00);
endmodule

// File: rtl/sprite_mem_arbiter.sv
module sprite_mem_arbiter
  import sprite_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hFE00,
  parameter int DEPTH = 160,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [1:0]        disp_mode,
  input  logic              copy_active,
  input  logic              copy_wr,
  input  logic [IDX_W-1:0]  copy_idx,
  input  logic [7:0]        copy_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_rvalid,
  output logic [IDX_W-1:0]  mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_en,
  output logic              mem_we
);
  logic             in_win;
  logic [IDX_W-1:0] cpu_off;
  logic             rd_req;
  logic             rd_open;
  logic [7:0]       ram_q;
  disp_mode_e       mode;

  assign mode = disp_mode_e'(disp_mode);

  sprite_win_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .DEPTH(DEPTH)) u_dec (
    .addr(cpu_addr), .in_win(in_win), .offset(cpu_off)
  );

  sprite_access_gate #(.DEPTH(DEPTH)) u_gate (
    .clk(clk), .rst_n(rst_n), .in_win(in_win), .cpu_off(cpu_off),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .mode(mode),
    .copy_active(copy_active), .copy_wr(copy_wr), .copy_idx(copy_idx),
    .copy_wdata(copy_wdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_req(rd_req), .rd_open(rd_open)
  );

  sprite_ram #(.DEPTH(DEPTH), .DATA_W(8)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .re(rd_req && rd_open), .raddr(cpu_off), .rdata(ram_q)
  );

  sprite_read_return u_ret (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_open(rd_open),
    .ram_q(ram_q), .rdata(cpu_rdata), .rvalid(cpu_rvalid)
  );

  // R3
  busy_phase_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && disp_mode[1] && cpu_addr >= BASE &&
     cpu_addr <= ADDR_W'(BASE + ADDR_W'(DEPTH - 1))) |=> cpu_rdata == 8'hFF);

  // R4
  copy_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && copy_active && cpu_addr >= BASE &&
     cpu_addr <= ADDR_W'(BASE + ADDR_W'(DEPTH - 1))) |=> cpu_rdata == 8'hFF);

  // R1
  outside_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && (cpu_addr < BASE || cpu_addr > ADDR_W'(BASE + ADDR_W'(DEPTH - 1))))
    |=> !cpu_rvalid);

  // R9
  we_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (copy_wr || cpu_wr));
endmodule

// File: tb/sprite_mem_arbiter_test.sv
`timescale 1ns/100ps
module sprite_mem_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [1:0]  disp_mode = '0;
  logic        copy_active = 1'b0, copy_wr = 1'b0;
  logic [7:0]  copy_idx = '0, copy_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic [7:0]  mem_addr, mem_wdata;
  logic        mem_en, mem_we;

  always #2.5 clk = ~clk;

  sprite_mem_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .disp_mode(disp_mode),
    .copy_active(copy_active), .copy_wr(copy_wr), .copy_idx(copy_idx),
    .copy_wdata(copy_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_en(mem_en), .mem_we(mem_we)
  );

  typedef struct {
    logic       v;
    logic [7:0] d;
    string      req;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] ref_mem [160];
  int         checks = 0;
  int         failures = 0;
  bit         done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One bus cycle: drive at the falling edge, predict, check the memory-side outputs.
  task automatic step(input logic [15:0] a, input logic [7:0] wd, input bit rd,
                      input bit wr, input logic [1:0] m, input bit cact,
                      input bit cwr, input logic [7:0] cidx, input logic [7:0] cd,
                      input string req);
    bit   win, open, cfire, exp_en, exp_we;
    int   off;
    exp_t e;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = wd; cpu_rd = rd; cpu_wr = wr; disp_mode = m;
    copy_active = cact; copy_wr = cwr; copy_idx = cidx; copy_wdata = cd;
    win   = (a >= 16'hFE00) && (a <= 16'hFE9F);
    off   = int'(a) - 16'hFE00;
    open  = !cact && (m == 2'd0 || m == 2'd1);
    cfire = cact && cwr && (cidx < 8'd160);
    exp_we = cfire || (win && wr && open);
    exp_en = exp_we || (win && rd && open);
    if (rd) begin
      e.v = win;
      e.d = !win ? 8'h00 : (open ? ref_mem[off] : 8'hFF);
      e.req = req;
      sb.push_back(e);
    end
    #1;
    check(mem_en == exp_en, {req, " mem_en"}, mem_en, exp_en);
    check(mem_we == exp_we, {req, " mem_we"}, mem_we, exp_we);
    if (exp_we && !cfire) begin
      check(mem_addr == off[7:0], {req, " R9 mem_addr"}, mem_addr, off);
      check(mem_wdata == wd, {req, " R9 mem_wdata"}, mem_wdata, wd);
    end
    if (cfire) ref_mem[cidx] = cd;
    else if (win && wr && open) ref_mem[off] = wd;
  endtask

  task automatic idle();
    step(16'h0000, 8'h00, 0, 0, 2'd0, 0, 0, 8'h00, 8'h00, "idle");
  endtask

  // Monitor: pops one expectation per read strobe, one cycle later.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (sb.size() > 0) begin
          exp_t e;
          e = sb.pop_front();
          check(cpu_rvalid == e.v, {e.req, " rvalid"}, cpu_rvalid, e.v);
          check(cpu_rdata == e.d, {e.req, " rdata"}, cpu_rdata, e.d);
        end else if (cpu_rvalid) begin
          check(1'b0, "R7 unexpected rvalid", cpu_rvalid, 0);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 160; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    // R8 reset state
    check(cpu_rvalid == 1'b0, "R8 rvalid", cpu_rvalid, 0);
    check(cpu_rdata == 8'h00, "R8 rdata", cpu_rdata, 0);
    check(mem_en == 1'b0, "R8 mem_en", mem_en, 0);
    @(negedge clk); rst_n = 1'b1;
    idle();

    // R2 fill the table in hblank, read back in vblank
    for (int i = 0; i < 160; i++)
      step(16'hFE00 + 16'(i), 8'(i * 7 + 3), 0, 1, 2'd0, 0, 0, 0, 0, "R2 R9 fill");
    for (int i = 0; i < 160; i++)
      step(16'hFE00 + 16'(i), 0, 1, 0, 2'd1, 0, 0, 0, 0, "R2 R7 readback");

    // R3 busy phases: write dropped, read all ones, then open read shows old value
    step(16'hFE10, 8'hAA, 0, 1, 2'd2, 0, 0, 0, 0, "R3 scan write");
    step(16'hFE11, 8'hBB, 0, 1, 2'd3, 0, 0, 0, 0, "R3 draw write");
    step(16'hFE10, 0, 1, 0, 2'd2, 0, 0, 0, 0, "R3 scan read");
    step(16'hFE11, 0, 1, 0, 2'd3, 0, 0, 0, 0, "R3 draw read");
    step(16'hFE10, 0, 1, 0, 2'd0, 0, 0, 0, 0, "R3 open read after drop");
    step(16'hFE11, 0, 1, 0, 2'd1, 0, 0, 0, 0, "R3 open read after drop");

    // R4 R5 copy active in blanking phases
    step(16'hFE20, 8'h55, 0, 1, 2'd0, 1, 0, 0, 0, "R4 R5 write while copying");
    step(16'hFE21, 8'h66, 0, 1, 2'd1, 1, 0, 0, 0, "R4 R5 write while copying");
    step(16'hFE20, 0, 1, 0, 2'd0, 1, 0, 0, 0, "R4 R5 read while copying");
    step(16'hFE21, 0, 1, 0, 2'd3, 1, 0, 0, 0, "R4 read while copying");
    step(16'hFE20, 0, 1, 0, 2'd0, 0, 0, 0, 0, "R4 R5 open read after");
    step(16'hFE21, 0, 1, 0, 2'd1, 0, 0, 0, 0, "R4 R5 open read after");

    // R6 copy port
    step(16'h0000, 0, 0, 0, 2'd3, 1, 1, 8'd5, 8'hC5, "R6 copy write draw");
    step(16'h0000, 0, 0, 0, 2'd2, 1, 1, 8'd159, 8'hD9, "R6 copy write last");
    step(16'h0000, 0, 0, 0, 2'd0, 1, 1, 8'd160, 8'hEE, "R6 copy index past end");
    step(16'h0000, 0, 0, 0, 2'd0, 0, 1, 8'd6, 8'h77, "R6 copy write inactive");
    step(16'hFE05, 0, 1, 0, 2'd0, 0, 0, 0, 0, "R6 read copied");
    step(16'hFE9F, 0, 1, 0, 2'd0, 0, 0, 0, 0, "R6 read copied last");
    step(16'hFE06, 0, 1, 0, 2'd1, 0, 0, 0, 0, "R6 read untouched");

    // R1 window edges and outside
    step(16'hFDFF, 8'h12, 0, 1, 2'd0, 0, 0, 0, 0, "R1 write below");
    step(16'hFEA0, 8'h34, 0, 1, 2'd0, 0, 0, 0, 0, "R1 write above");
    step(16'hFDFF, 0, 1, 0, 2'd0, 0, 0, 0, 0, "R1 read below");
    step(16'hFEA0, 0, 1, 0, 2'd0, 0, 0, 0, 0, "R1 read above");
    step(16'h0000, 0, 1, 0, 2'd1, 0, 0, 0, 0, "R1 read zero");
    step(16'hFE00, 0, 1, 0, 2'd0, 0, 0, 0, 0, "R1 read first");
    step(16'hFE9F, 8'h9F, 0, 1, 2'd1, 0, 0, 0, 0, "R1 R9 write last");
    step(16'hFE9F, 0, 1, 0, 2'd0, 0, 0, 0, 0, "R1 read last");

    // R7 gap between reads shows no response
    idle();
    idle();
    step(16'hFE40, 0, 1, 0, 2'd0, 0, 0, 0, 0, "R7 isolated read");
    idle();

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R7 pending responses", sb.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule